// File: doc/BRIEF.md
# March LR Memory Self-Test Controller

This block sits between a system bus and one single-port synchronous SRAM. While its test-enable input is low it is transparent: the system's address, write data and write strobe reach the memory unchanged. When test-enable goes high the block takes the memory port. It holds the port quiet for a short synchronisation phase and then runs a fixed March LR test over every word. It generates addresses, solid all-zero or all-one write data and the read/write control. It checks each read against the value the algorithm expects.

Two fail outputs report the result. A latched go/no-go flag rises on the first mismatch and holds. A strobe pulses once for every mismatching read, in a fixed cycle relation to the read that failed, so the failing address can be located. A done flag marks the end of the test. Dropping test-enable at any time abandons the test and gives the port back to the system.

Top module: `mbist_march_lr`

## Requirements
- R1: While test_en has been low for the current and the previous cycle, mem_addr, mem_wdata and mem_we equal sys_addr, sys_wdata and sys_we in the same cycle.
- R2: When test_en rises in cycle c, cycles c+1 to c+3 are a synchronisation phase with mem_we = 0 whatever the system drives. The first test access is issued in cycle c+4.
- R3: The test issues one access per cycle in this element order: {w0} ascending; {r0,w1} descending from address 2^AW-1 to 0; {r1,w0,r0,w1} ascending; {r1,w0} ascending; {r0,w1,r1,w0} ascending; {r0} ascending. All operations of an element are done at one address before the address steps. Ascending runs cover 0 to 2^AW-1. A read drives mem_we = 0 and a write drives mem_we = 1.
- R4: A w0 drives mem_wdata to all zeros and a w1 drives it to all ones. A read expects all zeros for r0 and all ones for r1.
- R5: fail_latched rises on the first mismatching read and stays high through done and after test_en falls. It is cleared only by reset or by a new rise of test_en, and it is low during the synchronisation phase.
- R6: A read issued in cycle k whose returned data (valid in cycle k+1) differs in any bit from its expected value makes fail_strobe high in cycle k+2 only. A matching read keeps it low in that cycle. fail_strobe is never high without fail_latched.
- R7: Reset (rst high at a clock edge) clears bist_done, fail_latched and fail_strobe and leaves the block transparent.
- R8: bist_done goes high two cycles after the final r0 is issued, which is the same cycle as that read's strobe. It stays high while test_en stays high and is low during the test.
- R9: If test_en is low in cycle c, then from cycle c+1 the block is transparent again and bist_done is low. A later rise of test_en starts a fresh test from the synchronisation phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for block and memory |
| rst | input | 1 | Synchronous active-high reset |
| test_en | input | 1 | High: run the self-test; low: transparent |
| sys_addr | input | AW | System address |
| sys_wdata | input | DW | System write data |
| sys_we | input | 1 | System write strobe |
| mem_rdata | input | DW | Memory read data, one cycle after the address |
| mem_addr | output | AW | Address to the memory |
| mem_wdata | output | DW | Write data to the memory |
| mem_we | output | 1 | Write strobe to the memory (1 = write, 0 = read) |
| bist_done | output | 1 | Test complete |
| fail_latched | output | 1 | Go/no-go: at least one mismatch seen |
| fail_strobe | output | 1 | One-cycle pulse per mismatching read |

## Verification
A wrong element counter, op index or address step shows at the memory port in the very cycle it goes wrong, as a wrong strobe, address or data word. The bench compares every access of every run. A comparator expecting the wrong polarity or using the wrong pipeline delay makes fail_strobe appear two cycles after an access that should not fail, or miss the cycle of an injected stuck bit. Stuck bits are injected at the lowest address, the highest address and random places. A bad end-of-test or abort path shows within one or two cycles on bist_done or on the port returning to the system.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    localparam int unsigned NUM_ELEM    = 6;
    localparam int unsigned ELEM_W      = 3;
    localparam int unsigned OPIDX_W     = 2;
    localparam int unsigned SYNC_CYCLES = 3;
    localparam int unsigned SYNC_W      = (SYNC_CYCLES > 1) ? $clog2(SYNC_CYCLES) : 1;

    localparam logic [ELEM_W-1:0] LAST_ELEM = ELEM_W'(NUM_ELEM - 1);
    localparam logic [SYNC_W-1:0] SYNC_LAST = SYNC_W'(SYNC_CYCLES - 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SYNC,
        ST_RUN,
        ST_FIN
    } seq_state_e;

    // one march operation: valid, read (1) / write (0), data polarity
    typedef struct packed {
        logic vld;
        logic rd;
        logic val;
    } march_op_t;

    // index of the last operation inside an element
    function automatic logic [OPIDX_W-1:0] elem_last_op(input logic [ELEM_W-1:0] e);
        case (e)
            3'd0:    return 2'd0;
            3'd1:    return 2'd1;
            3'd2:    return 2'd3;
            3'd3:    return 2'd1;
            3'd4:    return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    // only the second element walks the address space downwards
    function automatic logic elem_descending(input logic [ELEM_W-1:0] e);
        return (e == 3'd1);
    endfunction

    // {rd, val} for operation o of element e
    function automatic logic [1:0] op_code(input logic [ELEM_W-1:0] e,
                                           input logic [OPIDX_W-1:0] o);
        logic [1:0] c;
        c = 2'b00;
        case (e)
            3'd0: c = 2'b00;
            3'd1: c = (o == 2'd0) ? 2'b10 : 2'b01;
            3'd2: begin
                case (o)
                    2'd0:    c = 2'b11;
                    2'd1:    c = 2'b00;
                    2'd2:    c = 2'b10;
                    default: c = 2'b01;
                endcase
            end
            3'd3: c = (o == 2'd0) ? 2'b11 : 2'b00;
            3'd4: begin
                case (o)
                    2'd0:    c = 2'b10;
                    2'd1:    c = 2'b01;
                    2'd2:    c = 2'b11;
                    default: c = 2'b00;
                endcase
            end
            default: c = 2'b10;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mbist_seq.sv
module mbist_seq
    import mbist_pkg::*;
#(
    parameter int unsigned AW = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            test_en,
    output logic            own,
    output logic            start,
    output logic            done,
    output march_op_t       op,
    output logic [AW-1:0]   addr
);

    localparam logic [AW-1:0]      ADDR_MAX = {AW{1'b1}};
    localparam logic [AW-1:0]      ADDR_ONE = AW'(1);
    localparam logic [ELEM_W-1:0]  ELEM_ONE = ELEM_W'(1);
    localparam logic [OPIDX_W-1:0] OP_ONE   = OPIDX_W'(1);
    localparam logic [SYNC_W-1:0]  SYNC_ONE = SYNC_W'(1);

    seq_state_e         state, state_n;
    logic [SYNC_W-1:0]  sync_cnt, sync_cnt_n;
    logic [ELEM_W-1:0]  elem, elem_n;
    logic [OPIDX_W-1:0] op_idx, op_idx_n;
    logic [AW-1:0]      addr_q, addr_n;
    logic               done_q;

    logic               last_op;
    logic               last_addr;
    logic               desc;
    logic [ELEM_W-1:0]  elem_next;
    logic [1:0]         code;

    assign desc      = elem_descending(elem);
    assign last_op   = (op_idx == elem_last_op(elem));
    assign last_addr = desc ? (addr_q == '0) : (addr_q == ADDR_MAX);
    assign elem_next = elem + ELEM_ONE;

    always_comb begin
        state_n    = state;
        sync_cnt_n = sync_cnt;
        elem_n     = elem;
        op_idx_n   = op_idx;
        addr_n     = addr_q;
        if (!test_en) begin
            state_n = ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: begin
                    state_n    = ST_SYNC;
                    sync_cnt_n = '0;
                end
                ST_SYNC: begin
                    if (sync_cnt == SYNC_LAST) begin
                        state_n  = ST_RUN;
                        elem_n   = '0;
                        op_idx_n = '0;
                        addr_n   = elem_descending('0) ? ADDR_MAX : '0;
                    end else begin
                        sync_cnt_n = sync_cnt + SYNC_ONE;
                    end
                end
                ST_RUN: begin
                    if (!last_op) begin
                        op_idx_n = op_idx + OP_ONE;
                    end else begin
                        op_idx_n = '0;
                        if (!last_addr) begin
                            addr_n = desc ? (addr_q - ADDR_ONE) : (addr_q + ADDR_ONE);
                        end else if (elem == LAST_ELEM) begin
                            state_n = ST_FIN;
                        end else begin
                            elem_n = elem_next;
                            addr_n = elem_descending(elem_next) ? ADDR_MAX : '0;
                        end
                    end
                end
                default: state_n = ST_FIN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            sync_cnt <= '0;
            elem     <= '0;
            op_idx   <= '0;
            addr_q   <= '0;
            done_q   <= 1'b0;
        end else begin
            state    <= state_n;
            sync_cnt <= sync_cnt_n;
            elem     <= elem_n;
            op_idx   <= op_idx_n;
            addr_q   <= addr_n;
            done_q   <= (state == ST_FIN) && test_en;
        end
    end

    assign code   = op_code(elem, op_idx);
    assign op.vld = (state == ST_RUN);
    assign op.rd  = code[1];
    assign op.val = code[0];

    assign own   = (state != ST_IDLE);
    assign start = (state == ST_IDLE) && test_en;
    assign done  = done_q;
    assign addr  = (state == ST_RUN) ? addr_q : '0;

endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp
    import mbist_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          test_en,
    input  march_op_t     op,
    input  logic [DW-1:0] rdata,
    output logic          strobe,
    output logic          latched
);

    logic          pend;
    logic          exp_val;
    logic [DW-1:0] diff;
    logic          mismatch;

    // per-bit difference against the solid expected pattern
    for (genvar b = 0; b < DW; b++) begin : g_bit
        assign diff[b] = rdata[b] ^ exp_val;
    end

    assign mismatch = pend && (|diff);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= 1'b0;
            exp_val <= 1'b0;
            strobe  <= 1'b0;
            latched <= 1'b0;
        end else begin
            pend    <= op.vld && op.rd && test_en;
            exp_val <= op.val;
            strobe  <= mismatch;
            if (start) begin
                latched <= 1'b0;
            end else if (mismatch) begin
                latched <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/mbist_portmux.sv
module mbist_portmux
    import mbist_pkg::*;
#(
    parameter int unsigned AW = 4,
    parameter int unsigned DW = 8
) (
    input  logic            own,
    input  march_op_t       op,
    input  logic [AW-1:0]   bist_addr,
    input  logic [AW-1:0]   sys_addr,
    input  logic [DW-1:0]   sys_wdata,
    input  logic            sys_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic            mem_we
);

    logic [DW-1:0] pattern;
    logic          bist_we;

    assign pattern = {DW{op.val}};
    assign bist_we = op.vld && !op.rd;

    assign mem_addr  = own ? bist_addr : sys_addr;
    assign mem_wdata = own ? (op.vld ? pattern : '0) : sys_wdata;
    assign mem_we    = own ? bist_we : sys_we;

endmodule

// File: rtl/mbist_march_lr.sv
module mbist_march_lr
    import mbist_pkg::*;
#(
    parameter int unsigned AW = 4,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          test_en,
    input  logic [AW-1:0] sys_addr,
    input  logic [DW-1:0] sys_wdata,
    input  logic          sys_we,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    output logic          bist_done,
    output logic          fail_latched,
    output logic          fail_strobe
);

    logic          own;
    logic          start;
    march_op_t     op;
    logic [AW-1:0] bist_addr;

    mbist_seq #(.AW(AW)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .test_en (test_en),
        .own     (own),
        .start   (start),
        .done    (bist_done),
        .op      (op),
        .addr    (bist_addr)
    );

    mbist_cmp #(.DW(DW)) u_cmp (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .test_en (test_en),
        .op      (op),
        .rdata   (mem_rdata),
        .strobe  (fail_strobe),
        .latched (fail_latched)
    );

    mbist_portmux #(.AW(AW), .DW(DW)) u_mux (
        .own       (own),
        .op        (op),
        .bist_addr (bist_addr),
        .sys_addr  (sys_addr),
        .sys_wdata (sys_wdata),
        .sys_we    (sys_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we)
    );

endmodule

// File: rtl/mbist_march_lr_chk.sv
module mbist_march_lr_chk #(
    parameter int unsigned AW = 4,
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          test_en,
    input logic          own,
    input logic [AW-1:0] sys_addr,
    input logic [DW-1:0] sys_wdata,
    input logic          sys_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_we,
    input logic          bist_done,
    input logic          fail_latched,
    input logic          fail_strobe
);

    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    AST_PASS_THRU: assert property (@(posedge clk) disable iff (rst)
        (!test_en && $past(!test_en)) |->
            (mem_addr == sys_addr && mem_wdata == sys_wdata && mem_we == sys_we))
        else $error("pass-through broken"); // R1

    AST_SYNC_QUIET: assert property (@(posedge clk) disable iff (rst)
        $rose(test_en) |=> !mem_we)
        else $error("write during sync"); // R2

    AST_WRITE_PATTERN: assert property (@(posedge clk) disable iff (rst)
        (own && mem_we) |-> (mem_wdata == '0 || mem_wdata == '1))
        else $error("write data not solid"); // R4

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (fail_latched && !$rose(test_en)) |=> fail_latched)
        else $error("latched fail dropped"); // R5

    AST_STROBE_LATCH: assert property (@(posedge clk) disable iff (rst)
        fail_strobe |-> fail_latched)
        else $error("strobe without latch"); // R6

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst_d |-> (!bist_done && !fail_latched && !fail_strobe))
        else $error("reset did not clear"); // R7

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bist_done && test_en) |=> bist_done)
        else $error("done dropped"); // R8

    AST_ABORT_DONE: assert property (@(posedge clk) disable iff (rst)
        !test_en |=> (!bist_done && !own))
        else $error("abort not honoured"); // R9

endmodule

bind mbist_march_lr mbist_march_lr_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .test_en      (test_en),
    .own          (own),
    .sys_addr     (sys_addr),
    .sys_wdata    (sys_wdata),
    .sys_we       (sys_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_we       (mem_we),
    .bist_done    (bist_done),
    .fail_latched (fail_latched),
    .fail_strobe  (fail_strobe)
);

// File: tb/sim_mbist_march_lr.sv
`timescale 1ns/1ps
module sim_mbist_march_lr;

    localparam int AW     = 4;
    localparam int DW     = 8;
    localparam int NW     = 1 << AW;
    localparam int MAXOPS = 14 * NW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          test_en = 1'b0;
    logic [AW-1:0] sys_addr = '0;
    logic [DW-1:0] sys_wdata = '0;
    logic          sys_we = 1'b0;
    logic [DW-1:0] mem_rdata;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_we;
    logic          bist_done, fail_latched, fail_strobe;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // memory model with optional stuck bit
    logic [DW-1:0] mem [0:NW-1];
    bit f_on = 0;
    int f_addr = 0;
    int f_bit = 0;
    bit f_val = 0;

    always #4 clk = ~clk;

    mbist_march_lr #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst(rst), .test_en(test_en),
        .sys_addr(sys_addr), .sys_wdata(sys_wdata), .sys_we(sys_we),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .bist_done(bist_done), .fail_latched(fail_latched),
        .fail_strobe(fail_strobe)
    );

    always @(posedge clk) begin
        logic [DW-1:0] v;
        v = mem[mem_addr];
        if (f_on && int'(mem_addr) == f_addr) v[f_bit] = f_val;
        mem_rdata <= v;
        if (mem_we) mem[mem_addr] <= mem_wdata;
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int elem_ops(input int e);
        case (e)
            0, 5:    return 1;
            1, 3:    return 2;
            default: return 4;
        endcase
    endfunction

    // {rd, val}: r0=2 r1=3 w0=0 w1=1
    function automatic int elem_code(input int e, input int o);
        int t [6][4] = '{'{0,0,0,0}, '{2,1,0,0}, '{3,0,2,1},
                         '{3,0,0,0}, '{2,1,3,0}, '{2,0,0,0}};
        return t[e][o];
    endfunction

    task automatic drive_sys_random();
        sys_addr  = AW'($urandom);
        sys_wdata = DW'($urandom);
        sys_we    = 1'($urandom);
    endtask

    task automatic check_transparent(input string tag);
        chk({tag, " addr"}, mem_addr, sys_addr);
        chk({tag, " wdata"}, mem_wdata, sys_wdata);
        chk({tag, " we"}, mem_we, sys_we);
    endtask

    int  e_rd [MAXOPS];
    int  e_val [MAXOPS];
    int  e_addr [MAXOPS];
    bit  e_fail [MAXOPS];

    task automatic run_march(input bit fon, input int fa, input int fb, input bit fv,
                             input int abort_at);
        int n;
        int seq_err, dat_err, pul_err, sync_err;
        bit any;
        n = 0; any = 0;
        seq_err = 0; dat_err = 0; pul_err = 0; sync_err = 0;
        f_on = fon; f_addr = fa; f_bit = fb; f_val = fv;
        for (int e = 0; e < 6; e++) begin
            for (int ai = 0; ai < NW; ai++) begin
                for (int o = 0; o < elem_ops(e); o++) begin
                    int c;
                    c = elem_code(e, o);
                    e_rd[n]   = c / 2;
                    e_val[n]  = c % 2;
                    e_addr[n] = (e == 1) ? (NW - 1 - ai) : ai;
                    e_fail[n] = fon && (c / 2 == 1) && (e_addr[n] == fa) && (bit'(c % 2) != fv);
                    if (e_fail[n]) any = 1;
                    n++;
                end
            end
        end

        @(posedge clk); #1 test_en = 1'b1; drive_sys_random();
        @(posedge clk);
        for (int s = 0; s < 3; s++) begin
            #1 sys_we = 1'b1;
            @(negedge clk);
            if (mem_we !== 1'b0) sync_err++;
            if (s == 0) begin
                chk("R5 latch cleared in sync", fail_latched, 0);
                chk("R5 no strobe in sync", fail_strobe, 0);
            end
            @(posedge clk);
        end
        chk("R2 quiet sync cycles", sync_err, 0);

        for (int k = 0; k < n; k++) begin
            #1 drive_sys_random();
            @(negedge clk);
            if (mem_we !== (e_rd[k] == 0) || int'(mem_addr) != e_addr[k]) begin
                if (seq_err == 0)
                    $display("  op %0d: we=%0d addr=%0d, wanted rd=%0d addr=%0d",
                             k, mem_we, mem_addr, e_rd[k], e_addr[k]);
                seq_err++;
            end
            if (e_rd[k] == 0 && mem_wdata !== {DW{1'(e_val[k])}}) dat_err++;
            if (fail_strobe !== ((k >= 2) ? e_fail[k-2] : 1'b0)) pul_err++;
            if (bist_done !== 1'b0) seq_err++;
            if (k == abort_at) begin
                chk("R3 access order before abort", seq_err, 0);
                @(posedge clk); #1 test_en = 1'b0; drive_sys_random();
                @(posedge clk);
                @(negedge clk);
                check_transparent("R9 released after abort");
                chk("R9 done low after abort", bist_done, 0);
                return;
            end
            @(posedge clk);
        end
        @(negedge clk);
        if (fail_strobe !== e_fail[n-2]) pul_err++;
        chk("R8 done low before last strobe", bist_done, 0);
        @(posedge clk);
        @(negedge clk);
        if (fail_strobe !== e_fail[n-1]) pul_err++;
        chk("R8 done rises with final strobe", bist_done, 1);
        chk("R5 latched go/no-go", fail_latched, any);
        @(posedge clk);
        @(negedge clk);
        if (fail_strobe !== 1'b0) pul_err++;
        chk("R8 done holds", bist_done, 1);
        chk("R3 access order and addresses", seq_err, 0);
        chk("R4 solid write data", dat_err, 0);
        chk("R6 strobe timing per read", pul_err, 0);
        #1 test_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R8 done cleared after disable", bist_done, 0);
        chk("R5 latch held after disable", fail_latched, any);
        @(posedge clk); #1 drive_sys_random();
        @(negedge clk);
        check_transparent("R1 transparent after test");
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        for (int i = 0; i < NW; i++) mem[i] = DW'($urandom);
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R7 done after reset", bist_done, 0);
        chk("R7 latch after reset", fail_latched, 0);
        chk("R7 strobe after reset", fail_strobe, 0);
        for (int i = 0; i < 6; i++) begin
            @(posedge clk); #1 drive_sys_random();
            @(negedge clk);
            check_transparent("R1 transparent idle");
        end

        run_march(0, 0, 0, 0, -1);
        run_march(1, 0, 0, 1, -1);
        run_march(1, NW - 1, DW - 1, 0, -1);
        run_march(0, 0, 0, 0, 50);
        run_march(0, 0, 0, 0, -1);
        for (int r = 0; r < 3; r++)
            run_march(1, int'($urandom % NW), int'($urandom % DW), 1'($urandom), -1);
        run_march(1, 5, 3, 1, 120);

        // reset in the middle of a test
        @(posedge clk); #1 test_en = 1'b1;
        repeat (20) @(posedge clk);
        #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0; test_en = 1'b0;
        @(negedge clk);
        chk("R7 mid-test reset done", bist_done, 0);
        chk("R7 mid-test reset latch", fail_latched, 0);
        check_transparent("R7 transparent after reset");

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired R8 actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule